// File: doc/BRIEF.md
# Signed Multiplier with Selectable Pipeline Stages

This block multiplies two signed two's complement operands and returns the complete double-width product, with no truncation and no rounding. With the default widths the operands are 18 bits and the product is 36 bits. Three registers can be built in or left out. One sits on operand A, one on operand B, and one on the product. Each is chosen by its own parameter at elaboration, so the designer can trade latency for clock rate on each path on its own.

Every built-in register runs from the one clock. Each has a private clock enable and a private synchronous clear. With these, an operand register can hold a coefficient or a data sample while the other side keeps moving.

A narrower signed operand is used by sign-extending it to the full operand width. An unsigned operand is used by holding its top bit at zero and placing the value in the lower bits. An active-low asynchronous reset clears every built-in register. The reset is expected to be released in step with the clock.

Top module: `pipe_smul`

## Requirements
- R1: Operands are signed two's complement values of OP_A_W and OP_B_W bits. With the defaults these are 18 bits each, covering -131072 to +131071. The product is OP_A_W+OP_B_W bits wide, 36 with the defaults. For example, -131072 times -131072 gives +17179869184, and -131072 times +131071 gives -17179738112.
- R2: When the operands are held steady for at least the latency, p_out equals the exact signed product. This holds for every combination of the three stage parameters.
- R3: Latency in clock cycles equals the number of present input stages counted as one, plus one if the product stage is present.
  - With all stages present it is 2 cycles.
  - With only the A stage present, p_out is the A value registered at the previous edge times the current b_in.
  - With no stages present, p_out follows the inputs in the same cycle.
- R4: A high clear (a_clr, b_clr or p_clr) sets its register to zero at the next rising edge. The clear wins over that register's enable.
- R5: With its enable low and its clear low, a present register keeps its value across edges, whatever its input does.
- R6: When a stage is parameterised out, its enable and clear inputs have no effect on p_out.
- R7: While rst_n is low, every present register reads zero. A path with no registers is not affected by rst_n.
- R8: Unsigned use works as follows. With the operand top bits held at 0, the product is the unsigned product of the lower 17-bit values. For example, 131071 times 131071 gives 17179607041.
- R9: The A and B registers are enabled independently. An A value held with a_en low is combined with new B values loaded with b_en high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all stages |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_in | input | OP_A_W | Signed operand A |
| b_in | input | OP_B_W | Signed operand B |
| a_en | input | 1 | Clock enable of the A stage |
| a_clr | input | 1 | Synchronous clear of the A stage |
| b_en | input | 1 | Clock enable of the B stage |
| b_clr | input | 1 | Synchronous clear of the B stage |
| p_en | input | 1 | Clock enable of the product stage |
| p_clr | input | 1 | Synchronous clear of the product stage |
| p_out | output | OP_A_W+OP_B_W | Signed product |

## Verification
The assertions check on every clock cycle the following, in the configurations where they apply:
- the product clears after a product-stage clear;
- the product holds while its enable is low;
- a cleared A or B register propagates to a zero product one stage later;
- in the purely combinational configuration, a zero operand gives a zero product, and the product has the right sign.

Only the bench scenarios can show the rest:
- exact product values at the range corners;
- the exact latency in each configuration;
- coefficient hold on one operand while the other changes;
- the lack of effect of controls on bypassed stages;
- the clearing effect of asynchronous reset.

// File: rtl/pipe_smul_pkg.sv
package pipe_smul_pkg;

  // default operand width of one multiplier input
  localparam int unsigned DEF_OP_W = 18;

  // number of clock cycles from operands to product
  function automatic int unsigned stage_latency(input bit has_a, input bit has_b, input bit has_p);
    return ((has_a || has_b) ? 1 : 0) + (has_p ? 1 : 0);
  endfunction

endpackage

// File: rtl/pipe_smul_stage.sv
module pipe_smul_stage #(
  parameter int unsigned W       = 18,
  parameter bit          PRESENT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (PRESENT) begin : g_reg
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;

    // clear wins over enable; enable low holds
    always_comb begin
      q_nxt = q_r;
      if (clr) begin
        q_nxt = '0;
      end else if (en) begin
        q_nxt = d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= '0;
      end else begin
        q_r <= q_nxt;
      end
    end

    assign q = q_r;
  end else begin : g_wire
    logic unused_ctl;
    assign unused_ctl = ^{clk, rst_n, en, clr};
    assign q = d;
  end

endmodule

// File: rtl/pipe_smul_core.sv
module pipe_smul_core #(
  parameter int unsigned WA = 18,
  parameter int unsigned WB = 18,
  localparam int unsigned PW = WA + WB
) (
  input  logic [WA-1:0] a,
  input  logic [WB-1:0] b,
  output logic [PW-1:0] p
);

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  // sign-extend both operands to the product width, then keep the low PW bits
  assign a_ext = {{WB{a[WA-1]}}, a};
  assign b_ext = {{WA{b[WB-1]}}, b};
  assign p     = a_ext * b_ext;

endmodule

// File: rtl/pipe_smul.sv
module pipe_smul
  import pipe_smul_pkg::*;
#(
  parameter int unsigned OP_A_W      = DEF_OP_W,
  parameter int unsigned OP_B_W      = DEF_OP_W,
  parameter bit          HAS_A_STAGE = 1'b1,
  parameter bit          HAS_B_STAGE = 1'b1,
  parameter bit          HAS_P_STAGE = 1'b1,
  localparam int unsigned PROD_W     = OP_A_W + OP_B_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_A_W-1:0] a_in,
  input  logic [OP_B_W-1:0] b_in,
  input  logic              a_en,
  input  logic              a_clr,
  input  logic              b_en,
  input  logic              b_clr,
  input  logic              p_en,
  input  logic              p_clr,
  output logic [PROD_W-1:0] p_out
);

  logic [OP_A_W-1:0] a_q;
  logic [OP_B_W-1:0] b_q;
  logic [PROD_W-1:0] prod_raw;

  pipe_smul_stage #(.W(OP_A_W), .PRESENT(HAS_A_STAGE)) u_stage_a (
    .clk(clk), .rst_n(rst_n), .en(a_en), .clr(a_clr), .d(a_in), .q(a_q)
  );

  pipe_smul_stage #(.W(OP_B_W), .PRESENT(HAS_B_STAGE)) u_stage_b (
    .clk(clk), .rst_n(rst_n), .en(b_en), .clr(b_clr), .d(b_in), .q(b_q)
  );

  pipe_smul_core #(.WA(OP_A_W), .WB(OP_B_W)) u_core (
    .a(a_q), .b(b_q), .p(prod_raw)
  );

  pipe_smul_stage #(.W(PROD_W), .PRESENT(HAS_P_STAGE)) u_stage_p (
    .clk(clk), .rst_n(rst_n), .en(p_en), .clr(p_clr), .d(prod_raw), .q(p_out)
  );

endmodule

// File: rtl/pipe_smul_chk.sv
module pipe_smul_chk #(
  parameter int unsigned OP_A_W      = 18,
  parameter int unsigned OP_B_W      = 18,
  parameter bit          HAS_A_STAGE = 1'b1,
  parameter bit          HAS_B_STAGE = 1'b1,
  parameter bit          HAS_P_STAGE = 1'b1,
  localparam int unsigned PROD_W     = OP_A_W + OP_B_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_A_W-1:0] a_in,
  input logic [OP_B_W-1:0] b_in,
  input logic              a_en,
  input logic              a_clr,
  input logic              b_en,
  input logic              b_clr,
  input logic              p_en,
  input logic              p_clr,
  input logic [PROD_W-1:0] p_out
);

  logic unused_chk;
  assign unused_chk = ^{a_en, b_en};

  if (HAS_P_STAGE) begin : g_p
    p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      p_clr |=> (p_out == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_clr && !p_en) |=> $stable(p_out));

    if (HAS_A_STAGE) begin : g_a
      p_aclr_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_clr ##1 (p_en && !p_clr)) |=> (p_out == '0));
    end
    if (HAS_B_STAGE) begin : g_b
      p_bclr_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_clr ##1 (p_en && !p_clr)) |=> (p_out == '0));
    end
  end else begin : g_np
    if (HAS_A_STAGE) begin : g_a
      p_aclr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a_clr |=> (p_out == '0));
    end
    if (HAS_B_STAGE) begin : g_b
      p_bclr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        b_clr |=> (p_out == '0));
    end
    if (!HAS_A_STAGE && !HAS_B_STAGE) begin : g_comb
      p_zero_operand_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_in == '0) || (b_in == '0)) |-> (p_out == '0));

      p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_in != '0) && (b_in != '0)) |->
          (p_out[PROD_W-1] == (a_in[OP_A_W-1] ^ b_in[OP_B_W-1])));
    end
  end

endmodule

bind pipe_smul pipe_smul_chk #(
  .OP_A_W(OP_A_W), .OP_B_W(OP_B_W),
  .HAS_A_STAGE(HAS_A_STAGE), .HAS_B_STAGE(HAS_B_STAGE), .HAS_P_STAGE(HAS_P_STAGE)
) u_pipe_smul_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
  .a_en(a_en), .a_clr(a_clr), .b_en(b_en), .b_clr(b_clr),
  .p_en(p_en), .p_clr(p_clr), .p_out(p_out)
);

// File: tb/pipe_smul_bench.sv
`timescale 1ns/1ps
module pipe_smul_bench;
  localparam int W  = 18;
  localparam int PW = 36;

  logic clk = 1'b0;
  logic rst_n;
  logic signed [W-1:0] a, b;
  logic a_en, a_clr, b_en, b_clr, p_en, p_clr;
  logic [PW-1:0] p_full, p_comb, p_areg;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pipe_smul u_pipe_smul (
    .clk(clk), .rst_n(rst_n), .a_in(a), .b_in(b),
    .a_en(a_en), .a_clr(a_clr), .b_en(b_en), .b_clr(b_clr),
    .p_en(p_en), .p_clr(p_clr), .p_out(p_full)
  );

  pipe_smul #(.HAS_A_STAGE(1'b0), .HAS_B_STAGE(1'b0), .HAS_P_STAGE(1'b0)) u_pipe_smul_comb (
    .clk(clk), .rst_n(rst_n), .a_in(a), .b_in(b),
    .a_en(a_en), .a_clr(a_clr), .b_en(b_en), .b_clr(b_clr),
    .p_en(p_en), .p_clr(p_clr), .p_out(p_comb)
  );

  pipe_smul #(.HAS_A_STAGE(1'b1), .HAS_B_STAGE(1'b0), .HAS_P_STAGE(1'b0)) u_pipe_smul_areg (
    .clk(clk), .rst_n(rst_n), .a_in(a), .b_in(b),
    .a_en(a_en), .a_clr(a_clr), .b_en(b_en), .b_clr(b_clr),
    .p_en(p_en), .p_clr(p_clr), .p_out(p_areg)
  );

  function automatic logic [PW-1:0] ref_mul(input logic signed [W-1:0] x, input logic signed [W-1:0] y);
    logic signed [PW-1:0] xe, ye;
    xe = PW'(x);
    ye = PW'(y);
    return xe * ye;
  endfunction

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic all_on();
    a_en = 1'b1; b_en = 1'b1; p_en = 1'b1;
    a_clr = 1'b0; b_clr = 1'b0; p_clr = 1'b0;
  endtask

  // apply a pair, let it settle through the longest path, check every configuration
  task automatic apply_check(input logic signed [W-1:0] x, input logic signed [W-1:0] y, input string req);
    a = x; b = y;
    #1;
    chk({req, " comb"}, p_comb, ref_mul(x, y));
    tick(2);
    chk({req, " two-stage"}, p_full, ref_mul(x, y));
    chk({req, " a-stage"}, p_areg, ref_mul(x, y));
  endtask

  logic signed [W-1:0] sa [40];
  logic signed [W-1:0] sb [40];

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0;
    all_on();
    a = 18'sd5; b = 18'sd6;
    tick(2);
    // R7: registers zero under reset, combinational path unaffected
    chk("R7 reset two-stage", p_full, '0);
    chk("R7 reset a-stage", p_areg, '0);
    chk("R7 reset comb", p_comb, ref_mul(18'sd5, 18'sd6));
    rst_n = 1'b1;

    // R1 / R2 corners
    apply_check(-18'sd131072, -18'sd131072, "R1 min*min");
    chk("R1 min*min value", p_full, 36'd17179869184);
    apply_check(-18'sd131072, 18'sd131071, "R1 min*max");
    chk("R1 min*max value", p_full, -36'sd17179738112);
    apply_check(18'sd131071, 18'sd131071, "R2 max*max");
    apply_check(18'sd0, -18'sd77, "R2 zero");
    apply_check(-18'sd1, -18'sd1, "R2 minus one squared");
    apply_check(18'sd1, -18'sd1, "R2 one*minus one");

    // R8 unsigned use with top bits low
    apply_check(18'h1FFFF, 18'h1FFFF, "R8 unsigned");
    chk("R8 unsigned value", p_full, 36'd17179607041);

    // R2 random vectors
    for (int i = 0; i < 150; i++) begin
      apply_check(W'($urandom()), W'($urandom()), "R2 random");
    end

    // R3 streaming latency
    for (int i = 0; i < 40; i++) begin
      sa[i] = W'($urandom());
      sb[i] = W'($urandom());
    end
    for (int i = 0; i < 40; i++) begin
      if (i >= 2) chk("R3 two-cycle latency", p_full, ref_mul(sa[i-2], sb[i-2]));
      a = sa[i]; b = sb[i];
      #1;
      chk("R3 zero latency", p_comb, ref_mul(sa[i], sb[i]));
      if (i >= 1) chk("R3 one-cycle a path", p_areg, ref_mul(sa[i-1], sb[i]));
      tick(1);
    end

    // R4 clear priority over enable
    apply_check(18'sd1000, -18'sd3, "R4 setup");
    p_clr = 1'b1;
    tick(1);
    chk("R4 product clear", p_full, '0);
    p_clr = 1'b0;
    tick(1);
    chk("R4 product reload", p_full, ref_mul(18'sd1000, -18'sd3));
    a_clr = 1'b1;
    tick(1);
    chk("R4 a clear a-stage", p_areg, '0);
    a_clr = 1'b0;
    tick(1);
    chk("R4 a clear two-stage", p_full, '0);
    tick(1);
    chk("R4 a clear recover", p_full, ref_mul(18'sd1000, -18'sd3));
    b_clr = 1'b1;
    tick(1);
    b_clr = 1'b0;
    tick(1);
    chk("R4 b clear two-stage", p_full, '0);
    tick(1);
    chk("R4 b clear recover", p_full, ref_mul(18'sd1000, -18'sd3));

    // R5 hold with enable low
    p_en = 1'b0;
    a = 18'sd7; b = 18'sd9;
    tick(3);
    chk("R5 product hold", p_full, ref_mul(18'sd1000, -18'sd3));
    p_en = 1'b1;
    tick(2);
    chk("R5 product release", p_full, ref_mul(18'sd7, 18'sd9));

    // R9 hold A as coefficient while B moves
    a_en = 1'b0;
    a = -18'sd5; b = 18'sd11;
    tick(2);
    chk("R9 held a two-stage", p_full, ref_mul(18'sd7, 18'sd11));
    chk("R9 held a a-stage", p_areg, ref_mul(18'sd7, 18'sd11));
    chk("R9 comb follows", p_comb, ref_mul(-18'sd5, 18'sd11));
    a_en = 1'b1;
    tick(2);
    chk("R9 a reload", p_full, ref_mul(-18'sd5, 18'sd11));

    // R6 controls of bypassed stages do nothing
    b_en = 1'b0; b_clr = 1'b1; p_en = 1'b0; p_clr = 1'b1;
    a = 18'sd300; b = -18'sd400;
    #1;
    chk("R6 comb ignores controls", p_comb, ref_mul(18'sd300, -18'sd400));
    tick(1);
    chk("R6 a-stage ignores b/p controls", p_areg, ref_mul(18'sd300, -18'sd400));
    b = 18'sd2;
    #1;
    chk("R6 a-stage b path live", p_areg, ref_mul(18'sd300, 18'sd2));
    a_clr = 1'b1; a_en = 1'b0;
    tick(1);
    chk("R6 comb ignores a controls", p_comb, ref_mul(18'sd300, 18'sd2));
    all_on();

    // R7 reset mid-run
    apply_check(18'sd1234, 18'sd567, "R7 setup");
    rst_n = 1'b0;
    #1;
    chk("R7 async two-stage", p_full, '0);
    chk("R7 async a-stage", p_areg, '0);
    chk("R7 async comb", p_comb, ref_mul(18'sd1234, 18'sd567));
    tick(1);
    rst_n = 1'b1;
    tick(2);
    chk("R7 after release", p_full, ref_mul(18'sd1234, 18'sd567));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule